// File: doc/BRIEF.md
# Two-Level Chunk Address Translator

This block turns a logical chunk number into a physical chunk location for a wear-levelled storage array. The logical chunk number splits into a logical segment and a chunk offset. A coarse table gives every logical segment a base physical segment. A small override table holds entries for individual chunks that have been moved into reserved segments. Only moved chunks carry an entry, so chunk-level mapping costs storage only where it is used.

The override table is split into buckets, one per chunk offset. A lookup scans only the bucket for its offset, one slot per cycle. A matching override wins over the base table. A moved chunk keeps its offset inside its new physical segment. The response carries the physical segment, the offset, a flag that says whether an override matched, and the number of slot comparisons used.

Update ports insert or delete override entries and rewrite base entries. The logic that decides when to remap, and the logic that moves data, live outside this block.

Top module: `chunk_xlate`

## Requirements
- R1: With OFF_W offset bits (default 2, so 4 chunks per segment), the logical segment is reqLcn >> OFF_W and the offset is the low OFF_W bits of reqLcn. rspOff always returns that offset.
- R2: After reset, each base entry maps logical segment i to physical segment i. There are no override entries, reqReady is 1 and rspValid is 0.
- R3: If no valid entry in the offset's bucket matches the logical segment, rspPseg is the base entry for that segment, rspHot is 0 and rspCmp equals DEPTH.
- R4: If an entry in the offset's bucket matches the logical segment, rspPseg is that entry's physical segment and rspHot is 1.
- R5: Only the bucket of the target offset is searched. An entry for the same logical segment at another offset does not affect the result.
- R6: A lookup accepted on a clock edge scans slot k at the (k+1)-th following edge. A hit in slot k gives rspValid after k+1 cycles with rspCmp = k+1. A miss gives rspValid after DEPTH cycles.
- R7: A request is accepted when reqValid and reqReady are both 1. reqReady stays 0 until the response. rspValid is a single-cycle pulse.
- R8: An insert whose (segment, offset) already has an entry overwrites that entry's physical segment. Otherwise the insert takes the lowest-numbered free slot of the bucket.
- R9: A delete invalidates the matching entry, so later lookups miss. The freed slot is then the lowest free slot for later inserts.
- R10: An insert into a bucket whose slots are all valid, with no matching entry, has no effect.
- R11: A base write replaces the base entry of its logical segment, starting with the next lookup.
- R12: Override and base updates presented while reqReady is 0 are ignored.
- R13: rspPseg, rspOff, rspHot and rspCmp hold their values until the next rspValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request |
| reqLcn | input | LSEG_W+OFF_W | Logical chunk number |
| reqReady | output | 1 | Idle, able to accept a lookup or update |
| rspValid | output | 1 | Response pulse |
| rspPseg | output | PSEG_W | Physical segment of the chunk |
| rspOff | output | OFF_W | Chunk offset within the segment |
| rspHot | output | 1 | 1 if an override entry matched |
| rspCmp | output | CMP_W | Slot comparisons used |
| hotWrEn | input | 1 | Override update strobe |
| hotWrDel | input | 1 | 1 = delete, 0 = insert |
| hotWrLseg | input | LSEG_W | Override logical segment |
| hotWrOff | input | OFF_W | Override offset (bucket) |
| hotWrPseg | input | PSEG_W | Override physical segment |
| baseWrEn | input | 1 | Base entry write strobe |
| baseWrLseg | input | LSEG_W | Base entry index |
| baseWrPseg | input | PSEG_W | New base physical segment |

## Verification
A corrupt override slot or a lost valid bit shows up on the next lookup of that offset. It appears as a wrong rspHot or rspPseg, and usually also as a wrong rspCmp, because the slot position is visible in the comparison count. A stuck scan pointer or a bad state register shows up within DEPTH+1 cycles of a request, as a wrong response latency or a reqReady that never returns. Updates wrongly taken during a scan become visible on the first lookup after that scan.

// File: rtl/chunk_xlate_pkg.sv
package chunk_xlate_pkg;
  typedef struct packed {
    logic load;    // capture request, start scan
    logic finish;  // register response this edge
    logic updEn;   // updates allowed
  } xlt_ctl_t;
endpackage

// File: rtl/chunk_xlate_ctrl.sv
module chunk_xlate_ctrl
  import chunk_xlate_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             slotHit,
  output logic             reqReady,
  output logic [PTR_W-1:0] ptr,
  output xlt_ctl_t         ctl
);
  typedef enum logic {IDLE, SCAN} state_t;
  state_t state;
  logic   lastSlot;

  always_comb begin
    lastSlot   = (ptr == PTR_W'(DEPTH - 1));
    reqReady   = (state == IDLE);
    ctl.updEn  = (state == IDLE);
    ctl.load   = (state == IDLE) && reqValid;
    ctl.finish = (state == SCAN) && (slotHit || lastSlot);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= IDLE;
      ptr   <= '0;
    end else begin
      if (ctl.load) begin
        state <= SCAN;
        ptr   <= '0;
      end else if (ctl.finish) begin
        state <= IDLE;
      end else if (state == SCAN) begin
        ptr <= ptr + PTR_W'(1);
      end
    end
  end
endmodule

// File: rtl/chunk_xlate_dp.sv
module chunk_xlate_dp
  import chunk_xlate_pkg::*;
#(
  parameter int LSEG_W = 4,
  parameter int PSEG_W = 5,
  parameter int OFF_W  = 2,
  parameter int DEPTH  = 4,
  localparam int NSEG  = 1 << LSEG_W,
  localparam int NBKT  = 1 << OFF_W,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CMP_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  xlt_ctl_t                ctl,
  input  logic [PTR_W-1:0]        ptr,
  input  logic [LSEG_W+OFF_W-1:0] reqLcn,
  output logic                    slotHit,
  output logic                    rspValid,
  output logic [PSEG_W-1:0]       rspPseg,
  output logic [OFF_W-1:0]        rspOff,
  output logic                    rspHot,
  output logic [CMP_W-1:0]        rspCmp,
  input  logic                    hotWrEn,
  input  logic                    hotWrDel,
  input  logic [LSEG_W-1:0]       hotWrLseg,
  input  logic [OFF_W-1:0]        hotWrOff,
  input  logic [PSEG_W-1:0]       hotWrPseg,
  input  logic                    baseWrEn,
  input  logic [LSEG_W-1:0]       baseWrLseg,
  input  logic [PSEG_W-1:0]       baseWrPseg
);
  logic              hotVld  [NBKT][DEPTH];
  logic [LSEG_W-1:0] hotLseg [NBKT][DEPTH];
  logic [PSEG_W-1:0] hotPseg [NBKT][DEPTH];
  logic [PSEG_W-1:0] baseTab [NSEG];

  logic [LSEG_W-1:0] curLseg;
  logic [OFF_W-1:0]  curOff;

  logic             matchFound, freeFound;
  logic [PTR_W-1:0] matchIdx, freeIdx;

  // Lowest matching slot and lowest free slot of the update bucket
  always_comb begin
    matchFound = 1'b0;
    freeFound  = 1'b0;
    matchIdx   = '0;
    freeIdx    = '0;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      if (hotVld[hotWrOff][s] && (hotLseg[hotWrOff][s] == hotWrLseg)) begin
        matchFound = 1'b1;
        matchIdx   = PTR_W'(s);
      end
      if (!hotVld[hotWrOff][s]) begin
        freeFound = 1'b1;
        freeIdx   = PTR_W'(s);
      end
    end
  end

  assign slotHit = hotVld[curOff][ptr] && (hotLseg[curOff][ptr] == curLseg);

  // Override table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NBKT; b++) begin
        for (int s = 0; s < DEPTH; s++) begin
          hotVld[b][s]  <= 1'b0;
          hotLseg[b][s] <= '0;
          hotPseg[b][s] <= '0;
        end
      end
    end else if (ctl.updEn && hotWrEn) begin
      if (hotWrDel) begin
        if (matchFound) hotVld[hotWrOff][matchIdx] <= 1'b0;
      end else if (matchFound) begin
        hotPseg[hotWrOff][matchIdx] <= hotWrPseg;
      end else if (freeFound) begin
        hotVld[hotWrOff][freeIdx]  <= 1'b1;
        hotLseg[hotWrOff][freeIdx] <= hotWrLseg;
        hotPseg[hotWrOff][freeIdx] <= hotWrPseg;
      end
    end
  end

  // Base segment table, identity after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSEG; i++) baseTab[i] <= PSEG_W'(i);
    end else if (ctl.updEn && baseWrEn) begin
      baseTab[baseWrLseg] <= baseWrPseg;
    end
  end

  // Request capture and response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLseg  <= '0;
      curOff   <= '0;
      rspValid <= 1'b0;
      rspPseg  <= '0;
      rspOff   <= '0;
      rspHot   <= 1'b0;
      rspCmp   <= '0;
    end else begin
      rspValid <= ctl.finish;
      if (ctl.load) begin
        curLseg <= reqLcn[LSEG_W+OFF_W-1:OFF_W];
        curOff  <= reqLcn[OFF_W-1:0];
      end
      if (ctl.finish) begin
        rspPseg <= slotHit ? hotPseg[curOff][ptr] : baseTab[curLseg];
        rspOff  <= curOff;
        rspHot  <= slotHit;
        rspCmp  <= CMP_W'(ptr) + CMP_W'(1);
      end
    end
  end
endmodule

// File: rtl/chunk_xlate.sv
module chunk_xlate
  import chunk_xlate_pkg::*;
#(
  parameter int LSEG_W = 4,
  parameter int PSEG_W = 5,
  parameter int OFF_W  = 2,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CMP_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [LSEG_W+OFF_W-1:0] reqLcn,
  output logic                    reqReady,
  output logic                    rspValid,
  output logic [PSEG_W-1:0]       rspPseg,
  output logic [OFF_W-1:0]        rspOff,
  output logic                    rspHot,
  output logic [CMP_W-1:0]        rspCmp,
  input  logic                    hotWrEn,
  input  logic                    hotWrDel,
  input  logic [LSEG_W-1:0]       hotWrLseg,
  input  logic [OFF_W-1:0]        hotWrOff,
  input  logic [PSEG_W-1:0]       hotWrPseg,
  input  logic                    baseWrEn,
  input  logic [LSEG_W-1:0]       baseWrLseg,
  input  logic [PSEG_W-1:0]       baseWrPseg
);
  xlt_ctl_t         ctl;
  logic [PTR_W-1:0] ptr;
  logic             slotHit;

  chunk_xlate_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .slotHit(slotHit),
    .reqReady(reqReady), .ptr(ptr), .ctl(ctl)
  );

  chunk_xlate_dp #(
    .LSEG_W(LSEG_W), .PSEG_W(PSEG_W), .OFF_W(OFF_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ptr(ptr), .reqLcn(reqLcn),
    .slotHit(slotHit), .rspValid(rspValid), .rspPseg(rspPseg),
    .rspOff(rspOff), .rspHot(rspHot), .rspCmp(rspCmp),
    .hotWrEn(hotWrEn), .hotWrDel(hotWrDel), .hotWrLseg(hotWrLseg),
    .hotWrOff(hotWrOff), .hotWrPseg(hotWrPseg),
    .baseWrEn(baseWrEn), .baseWrLseg(baseWrLseg), .baseWrPseg(baseWrPseg)
  );
endmodule

// File: rtl/chunk_xlate_chk.sv
module chunk_xlate_chk #(
  parameter int PSEG_W = 5,
  parameter int OFF_W  = 2,
  parameter int DEPTH  = 4,
  localparam int CMP_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [PSEG_W-1:0] rspPseg,
  input logic [OFF_W-1:0]  rspOff,
  input logic              rspHot,
  input logic [CMP_W-1:0]  rspCmp
);
  // R7
  acc_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6
  rsp_after_scan_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!reqReady));

  // R6
  cmp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspCmp >= CMP_W'(1)) && (rspCmp <= CMP_W'(DEPTH)));

  // R3
  miss_full_scan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHot) |-> (rspCmp == CMP_W'(DEPTH)));

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> ($stable(rspPseg) && $stable(rspOff) && $stable(rspHot) && $stable(rspCmp)));
endmodule

bind chunk_xlate chunk_xlate_chk #(.PSEG_W(PSEG_W), .OFF_W(OFF_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspPseg(rspPseg), .rspOff(rspOff),
  .rspHot(rspHot), .rspCmp(rspCmp)
);

// File: tb/sim_chunk_xlate.sv
`timescale 1ns/1ps
module sim_chunk_xlate;
  localparam int LSEG_W = 4;
  localparam int PSEG_W = 5;
  localparam int OFF_W  = 2;
  localparam int DEPTH  = 4;
  localparam int CMP_W  = $clog2(DEPTH + 1);
  localparam int NSEG   = 1 << LSEG_W;
  localparam int NBKT   = 1 << OFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [LSEG_W+OFF_W-1:0] reqLcn = '0;
  logic reqReady, rspValid, rspHot;
  logic [PSEG_W-1:0] rspPseg;
  logic [OFF_W-1:0] rspOff;
  logic [CMP_W-1:0] rspCmp;
  logic hotWrEn = 1'b0, hotWrDel = 1'b0;
  logic [LSEG_W-1:0] hotWrLseg = '0;
  logic [OFF_W-1:0] hotWrOff = '0;
  logic [PSEG_W-1:0] hotWrPseg = '0;
  logic baseWrEn = 1'b0;
  logic [LSEG_W-1:0] baseWrLseg = '0;
  logic [PSEG_W-1:0] baseWrPseg = '0;

  int tests = 0;
  int fails = 0;

  // model from the requirements
  bit mVld [NBKT][DEPTH];
  int mLseg [NBKT][DEPTH];
  int mPseg [NBKT][DEPTH];
  int mBase [NSEG];

  always #2.5 clk = ~clk;

  chunk_xlate #(.LSEG_W(LSEG_W), .PSEG_W(PSEG_W), .OFF_W(OFF_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLcn(reqLcn),
    .reqReady(reqReady), .rspValid(rspValid), .rspPseg(rspPseg),
    .rspOff(rspOff), .rspHot(rspHot), .rspCmp(rspCmp),
    .hotWrEn(hotWrEn), .hotWrDel(hotWrDel), .hotWrLseg(hotWrLseg),
    .hotWrOff(hotWrOff), .hotWrPseg(hotWrPseg),
    .baseWrEn(baseWrEn), .baseWrLseg(baseWrLseg), .baseWrPseg(baseWrPseg)
  );

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic modelIns(int ls, int off, int ps);
    for (int s = 0; s < DEPTH; s++)
      if (mVld[off][s] && mLseg[off][s] == ls) begin mPseg[off][s] = ps; return; end
    for (int s = 0; s < DEPTH; s++)
      if (!mVld[off][s]) begin
        mVld[off][s] = 1; mLseg[off][s] = ls; mPseg[off][s] = ps; return;
      end
  endtask

  task automatic modelDel(int ls, int off);
    for (int s = 0; s < DEPTH; s++)
      if (mVld[off][s] && mLseg[off][s] == ls) mVld[off][s] = 0;
  endtask

  task automatic hotUpd(bit del, int ls, int off, int ps);
    @(negedge clk);
    hotWrEn = 1; hotWrDel = del; hotWrLseg = LSEG_W'(ls);
    hotWrOff = OFF_W'(off); hotWrPseg = PSEG_W'(ps);
    @(negedge clk);
    hotWrEn = 0;
    if (del) modelDel(ls, off); else modelIns(ls, off, ps);
  endtask

  task automatic baseUpd(int ls, int ps);
    @(negedge clk);
    baseWrEn = 1; baseWrLseg = LSEG_W'(ls); baseWrPseg = PSEG_W'(ps);
    @(negedge clk);
    baseWrEn = 0;
    mBase[ls] = ps;
  endtask

  // Drive one lookup and check every response field against the model
  task automatic lookup(string tag, int ls, int off, bit busyUpd);
    int expHit = 0, expCmp = DEPTH, expPs = mBase[ls], lat = 0;
    for (int s = DEPTH - 1; s >= 0; s--)
      if (mVld[off][s] && mLseg[off][s] == ls) begin
        expHit = 1; expCmp = s + 1; expPs = mPseg[off][s];
      end
    @(negedge clk);
    reqValid = 1; reqLcn = (LSEG_W + OFF_W)'((ls << OFF_W) | off);
    @(posedge clk); #1;
    reqValid = 0;
    if (busyUpd) begin
      hotWrEn = 1; hotWrDel = 0; hotWrLseg = 9; hotWrOff = 3; hotWrPseg = 17;
      baseWrEn = 1; baseWrLseg = 9; baseWrPseg = 12;
    end
    while (1) begin
      @(posedge clk); #1;
      lat++;
      if (rspValid || lat > 20) break;
      // R7 ready stays low while scanning
      chk(tag, "reqReady during scan (R7)", reqReady, 0);
    end
    hotWrEn = 0; baseWrEn = 0;
    chk(tag, "latency (R6)", lat, expCmp);
    chk(tag, "rspCmp (R6)", rspCmp, expCmp);
    chk(tag, "rspHot (R3/R4)", rspHot, expHit);
    chk(tag, "rspPseg", rspPseg, expPs);
    chk(tag, "rspOff (R1)", rspOff, off);
    @(posedge clk); #1;
    chk(tag, "rspValid pulse (R7)", rspValid, 0);
  endtask

  task automatic tResetAndMiss();
    chk("R2", "reqReady after reset", reqReady, 1);
    chk("R2", "rspValid after reset", rspValid, 0);
    lookup("R2", 7, 1, 0);   // identity map, lcn 29
    lookup("R3", 12, 3, 0);
  endtask

  task automatic tBaseWrite();
    baseUpd(7, 19);
    lookup("R11", 7, 1, 0);
  endtask

  task automatic tHitAndBucket();
    hotUpd(0, 7, 1, 20);
    lookup("R4", 7, 1, 0);
    lookup("R5", 7, 2, 0);    // same segment, other offset
    hotUpd(0, 3, 2, 21);
    lookup("R5", 7, 2, 0);
    lookup("R4", 3, 2, 0);
  endtask

  task automatic tFullBucket();
    hotUpd(0, 1, 0, 24);
    hotUpd(0, 2, 0, 25);
    hotUpd(0, 3, 0, 26);
    hotUpd(0, 4, 0, 27);
    lookup("R6", 4, 0, 0);    // last slot, worst case
    hotUpd(0, 5, 0, 28);      // bucket full
    lookup("R10", 5, 0, 0);
    lookup("R10", 1, 0, 0);
  endtask

  task automatic tOverwriteDelete();
    hotUpd(0, 2, 0, 30);
    lookup("R8", 2, 0, 0);
    hotUpd(1, 2, 0, 0);
    lookup("R9", 2, 0, 0);
    hotUpd(0, 6, 0, 31);      // reuses slot 1
    lookup("R9", 6, 0, 0);
  endtask

  task automatic tBusyUpdate();
    lookup("R12", 4, 0, 1);
    lookup("R12", 9, 3, 0);   // insert and base write were ignored
  endtask

  task automatic tHold();
    int ps = rspPseg, cmp = rspCmp;
    repeat (4) @(posedge clk);
    #1;
    chk("R13", "rspPseg hold", rspPseg, ps);
    chk("R13", "rspCmp hold", rspCmp, cmp);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSEG; i++) mBase[i] = i;
    for (int b = 0; b < NBKT; b++)
      for (int s = 0; s < DEPTH; s++) mVld[b][s] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    tResetAndMiss();
    tBaseWrite();
    tHitAndBucket();
    tFullBucket();
    tOverwriteDelete();
    tBusyUpdate();
    tHold();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule